// File: doc/BRIEF.md
# Warp Scratchpad Bank Conflict Meter

This block looks at one warp-wide access to a banked scratchpad and works out how many serialized cycles the banks would need to serve it. The scratchpad has 32 banks, and each bank holds 4-byte words. A request carries one 16-bit word address for each of the 32 lanes, plus a per-lane mask that marks which lanes take part. The block sorts the active lanes into banks and counts the distinct words that land in each bank. It then reports the largest of those counts as the conflict degree.

Lanes that name exactly the same word are served together by a broadcast, so they add only one to their bank's count. Lanes whose mask bit is low play no part in the result. The result is registered. Alongside the degree, the block gives the full per-bank count vector and a flag that marks a conflict-free access. An arbiter or a performance monitor can use these outputs to predict the replay cost of a scratchpad instruction before it issues.

Top module: `bank_conflict_meter`

## Requirements
- R1: The bank of a lane is the low 5 bits of its word address (word index modulo 32). The count for bank b sits in `out_bank_cnt[b*6 +: 6]`.
- R2: The count of each bank is the number of distinct word addresses among the active lanes that map to that bank. Active lanes with identical addresses add one to the count, not one each.
- R3: A lane whose `in_mask` bit is 0 has no effect on any count, whatever its address.
- R4: `out_degree` equals the largest per-bank count. A request with no active lanes reports degree 0 and all bank counts 0.
- R5: `out_clean` is 1 exactly when `out_degree` is 0 or 1.
- R6: `in_ready` is always 1. A request is accepted on a clock edge where `in_valid` is 1. `out_valid` is 1 for exactly the one cycle after the accept, and that cycle carries that request's result. `out_valid` is 0 after any cycle that has no accept.
- R7: A full warp with a stride of 2 words gives degree 2, with count 2 on each even bank and 0 on each odd bank.
- R8: A full warp with an odd word stride gives degree 1, with count 1 on every bank.
- R9: While reset (active-low `rst_n`) is held and after it is released, `out_valid`, `out_degree`, `out_clean` and all bank counts are 0 until the first accept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken (always 1) |
| in_addr | input | 512 | Lane i word address in bits [i*16 +: 16] |
| in_mask | input | 32 | Lane i active when bit i is 1 |
| out_valid | output | 1 | Result valid, one cycle after accept |
| out_degree | output | 6 | Worst-case distinct words in one bank |
| out_bank_cnt | output | 192 | Bank b count in bits [b*6 +: 6] |
| out_clean | output | 1 | Degree is 0 or 1 |

## Verification
The hardest case to reach is a bank that holds a mix of repeated and distinct words at the same time. Here broadcast merging must cut the count without hiding a real collision, and the state of the masked lanes must not matter. Random address vectors almost never produce this. The stimulus therefore builds it on purpose. It writes the same word into several lanes, and it writes words that share the low 5 bits but differ in the upper bits into the same bank. It also loads inactive lanes with colliding addresses to act as decoys. Every result is compared against a behavioural per-bank list model on each clock.

// File: rtl/bank_conflict_meter.sv
module bank_conflict_meter #(
  parameter int LANES = 32,
  parameter int BANKS = 32,
  parameter int AW    = 16,
  localparam int BW   = $clog2(BANKS),
  localparam int CW   = $clog2(LANES + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [LANES*AW-1:0]   in_addr,
  input  logic [LANES-1:0]      in_mask,
  output logic                  out_valid,
  output logic [CW-1:0]         out_degree,
  output logic [BANKS*CW-1:0]   out_bank_cnt,
  output logic                  out_clean
);

  logic [AW-1:0]    word [LANES];
  logic [LANES-1:0] lead;
  logic [CW-1:0]    cnt  [BANKS];
  logic [CW-1:0]    deg;

  assign in_ready = 1'b1;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign word[i] = in_addr[i*AW +: AW];

    // a lane leads when no earlier active lane names the same word
    always_comb begin
      lead[i] = in_mask[i];
      for (int j = 0; j < LANES; j++)
        if (j < i && in_mask[j] && word[j] == word[i]) lead[i] = 1'b0;
    end
  end

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    always_comb begin
      cnt[b] = '0;
      for (int i = 0; i < LANES; i++)
        if (lead[i] && word[i][BW-1:0] == BW'(b)) cnt[b] = cnt[b] + CW'(1);
    end
  end

  always_comb begin
    deg = '0;
    for (int b = 0; b < BANKS; b++)
      if (cnt[b] > deg) deg = cnt[b];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_degree   <= '0;
      out_bank_cnt <= '0;
      out_clean    <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_degree <= deg;
        out_clean  <= (deg <= CW'(1));
        for (int b = 0; b < BANKS; b++) out_bank_cnt[b*CW +: CW] <= cnt[b];
      end
    end
  end

endmodule

module bank_conflict_meter_chk #(
  parameter int LANES = 32,
  parameter int BANKS = 32,
  parameter int AW    = 16,
  localparam int CW   = $clog2(LANES + 1)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic                in_ready,
  input logic [LANES*AW-1:0] in_addr,
  input logic [LANES-1:0]    in_mask,
  input logic                out_valid,
  input logic [CW-1:0]       out_degree,
  input logic [BANKS*CW-1:0] out_bank_cnt,
  input logic                out_clean
);

  AST_ACCEPT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> !out_valid); // R6
  AST_CLEAN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_clean == (out_degree <= CW'(1)))); // R5
  AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_mask == '0) |=> (out_degree == '0 && out_bank_cnt == '0)); // R4
  AST_DEGREE_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (int'(out_degree) <= $countones($past(in_mask)))); // R3

  for (genvar b = 0; b < BANKS; b++) begin : g_chk
    AST_BANK_UNDER_MAX: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_bank_cnt[b*CW +: CW] <= out_degree)); // R4
  end

endmodule

bind bank_conflict_meter bank_conflict_meter_chk #(.LANES(LANES), .BANKS(BANKS), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_addr(in_addr), .in_mask(in_mask), .out_valid(out_valid),
  .out_degree(out_degree), .out_bank_cnt(out_bank_cnt), .out_clean(out_clean));

// File: tb/bank_conflict_meter_tb.sv
module bank_conflict_meter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int L  = 32;
  localparam int B  = 32;
  localparam int AW = 16;
  localparam int CW = 6;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid;
  logic in_ready;
  logic [L*AW-1:0] in_addr;
  logic [L-1:0]    in_mask;
  logic out_valid;
  logic [CW-1:0]   out_degree;
  logic [B*CW-1:0] out_bank_cnt;
  logic out_clean;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  bit exp_v;
  int exp_deg;
  int exp_cnt [B];

  always #(CLK_PERIOD/2) clk = ~clk;

  bank_conflict_meter dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .in_mask(in_mask), .out_valid(out_valid),
    .out_degree(out_degree), .out_bank_cnt(out_bank_cnt), .out_clean(out_clean));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural model: per-bank list of distinct words
  task automatic model(input logic [L*AW-1:0] a, input logic [L-1:0] m);
    exp_deg = 0;
    for (int b = 0; b < B; b++) begin
      int seen [$];
      for (int i = 0; i < L; i++) begin
        int w = int'(a[i*AW +: AW]);
        if (m[i] && (w % B) == b) begin
          bit found = 0;
          foreach (seen[k]) if (seen[k] == w) found = 1;
          if (!found) seen.push_back(w);
        end
      end
      exp_cnt[b] = seen.size();
      if (exp_cnt[b] > exp_deg) exp_deg = exp_cnt[b];
    end
  endtask

  task automatic compare(input string ctx);
    chk({ctx, " R6 out_valid"}, int'(out_valid), int'(exp_v));
    if (exp_v) begin
      chk({ctx, " R4 degree"}, int'(out_degree), exp_deg);
      chk({ctx, " R5 clean"}, int'(out_clean), int'(exp_deg <= 1));
      for (int b = 0; b < B; b++)
        chk($sformatf("%s R1 R2 bank %0d", ctx, b), int'(out_bank_cnt[b*CW +: CW]), exp_cnt[b]);
    end
  endtask

  // drive at negedge, check the registered result at the next negedge
  task automatic step(input string ctx, input bit v, input logic [L*AW-1:0] a, input logic [L-1:0] m);
    in_valid = v; in_addr = a; in_mask = m;
    if (v) model(a, m);
    @(posedge clk);
    @(negedge clk);
    exp_v = v;
    compare(ctx);
    in_valid = 1'b0;
  endtask

  function automatic logic [L*AW-1:0] stride(input int base, input int s);
    logic [L*AW-1:0] r;
    for (int i = 0; i < L; i++) r[i*AW +: AW] = AW'(base + i * s);
    return r;
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [L*AW-1:0] a;
    logic [L-1:0] m;
    rst_n = 1'b0; in_valid = 1'b0; in_addr = '0; in_mask = '0;
    repeat (3) @(negedge clk);
    chk("R9 reset out_valid", int'(out_valid), 0);
    chk("R9 reset degree", int'(out_degree), 0);
    chk("R9 reset counts", int'(out_bank_cnt == '0), 1);
    chk("R9 reset clean", int'(out_clean), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 after release out_valid", int'(out_valid), 0);
    chk("R6 in_ready", int'(in_ready), 1);

    step("stride2", 1'b1, stride(0, 2), '1);
    chk("R7 stride2 degree", int'(out_degree), 2);
    chk("R7 even bank", int'(out_bank_cnt[4*CW +: CW]), 2);
    chk("R7 odd bank", int'(out_bank_cnt[5*CW +: CW]), 0);

    step("stride3", 1'b1, stride(7, 3), '1);
    chk("R8 stride3 degree", int'(out_degree), 1);
    chk("R8 clean", int'(out_clean), 1);
    step("stride5", 1'b1, stride(100, 5), '1);
    chk("R8 stride5 degree", int'(out_degree), 1);

    step("idle", 1'b0, stride(0, 32), '1);
    step("stride32", 1'b1, stride(0, 32), '1);
    chk("R1 stride32 degree", int'(out_degree), 32);
    chk("R5 stride32 not clean", int'(out_clean), 0);

    step("broadcast", 1'b1, stride(16'h1234, 0), '1);
    chk("R2 broadcast degree", int'(out_degree), 1);

    step("empty", 1'b1, stride(0, 32), '0);
    chk("R4 empty degree", int'(out_degree), 0);
    chk("R5 empty clean", int'(out_clean), 1);

    // mixed: duplicates plus distinct words in bank 3, decoys in inactive lanes
    a = stride(0, 1); m = '0;
    for (int i = 0; i < 8; i++) begin a[i*AW +: AW] = 16'h0003; m[i] = 1'b1; end
    a[8*AW +: AW] = 16'h0023; m[8] = 1'b1;
    a[9*AW +: AW] = 16'h0023; m[9] = 1'b1;
    a[10*AW +: AW] = 16'h8003; m[10] = 1'b1;
    for (int i = 11; i < L; i++) a[i*AW +: AW] = AW'(16'h0100 + i * 32 + 3);
    step("mixed", 1'b1, a, m);
    chk("R3 R2 mixed degree", int'(out_degree), 3);

    // masked lanes only differ: result must match full-decoy-free version
    m = 32'h0000_00FF;
    step("decoy", 1'b1, a, m);
    chk("R3 decoy degree", int'(out_degree), 1);

    // back-to-back random requests
    for (int n = 0; n < 200; n++) begin
      for (int i = 0; i < L; i++) a[i*AW +: AW] = AW'($urandom_range(0, (n % 4 == 0) ? 63 : 65535));
      m = $urandom();
      step("random", 1'b1, a, m);
    end
    step("tail idle", 1'b0, '0, '0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule